// File: doc/BRIEF.md
# Programmable Input Glitch Filter

This block cleans up one asynchronous digital input before other logic on the chip uses it. The raw level first passes through a two-flop synchronizer into the system clock domain. It then reaches a counting filter. The filter lets a new level through only after that level has been held for a programmed number of filter-clock periods. Shorter pulses are discarded.

The minimum width comes from a 4-bit one-hot code. An all-zero code, or any code that is not one-hot, turns filtering off, and the synchronized level is then registered straight to the output. A select input picks the filter time base. It can be every system-clock cycle, or a single-cycle enable pulse from a prescaler outside this block. Whoever uses the filtered level sees it as a plain registered signal.

Top module: `glitch_filt`

## Requirements
- R1: While rst_ni is low, and in the first cycle after it is released, filt_o is 0.
- R2: With width_code_i = 4'b0000 (bypass), a raw level change made just after a clock edge appears on filt_o at the third rising edge after it. Any pulse of at least one cycle is passed.
- R3: Any width_code_i value that is neither zero nor one-hot (for example 4'b0011, 4'b0110, 4'b1111) behaves exactly like bypass (R2).
- R4: With a one-hot code, bit k set (k = 0..3) sets the minimum width N = 2^(k+1): 2, 4, 8 or 16 filter periods. With fclk_sel_i = 1, a level held for N or more cycles changes filt_o at rising edge N+2 after the raw change. That is a 3-stage pipeline plus N-1 counting cycles.
- R5: In filtered mode, a raw pulse of N-1 cycles leaves filt_o unchanged.
- R6: With fclk_sel_i = 0, only cycles with tick_i = 1 count as filter periods. While tick_i stays 0, filt_o does not change, however long the new level is held. filt_o changes on the N-th counted tick.
- R7: The width count clears whenever the synchronized input equals filt_o. Separate short pulses therefore never add up to a passing width.
- R8: A change of width_code_i restarts the count. The held level then needs N full periods of the new code, counted from the cycle after the change.
- R9: With fclk_sel_i = 1, tick_i has no effect. Filtering with tick_i held at 0 meets the timing of R4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| raw_i | input | 1 | Asynchronous input level to be filtered |
| width_code_i | input | 4 | One-hot minimum-width code; zero or non-one-hot bypasses the filter |
| fclk_sel_i | input | 1 | Filter time base: 1 = every clock cycle, 0 = cycles with tick_i high |
| tick_i | input | 1 | Prescaled filter-clock enable, one cycle wide |
| filt_o | output | 1 | Filtered, registered level |

## Verification
The hardest case to reach from the ports is a width-code change partway through a count. This case only tells anything if the old count, carried over, would already satisfy the new width. The stimulus therefore starts a long hold under the 16-period code. It switches to the 4-period code once three periods have been counted, which would pass at once if the count were kept. It then checks that the output waits four further cycles. The prescaled time base is driven in the same way: the level is held with the tick idle, and then single tick pulses are placed so that the edge on which the output switches is known exactly.

// File: rtl/glitch_filt_pkg.sv
package glitch_filt_pkg;

  typedef enum logic {
    FCLK_PRESCALED = 1'b0,
    FCLK_MAIN      = 1'b1
  } fclk_sel_e;

  // bit k of the width code -> 2^(k+1) filter periods
  function automatic int unsigned periods_for_bit(input int unsigned k);
    return 32'd2 << k;
  endfunction

endpackage

// File: rtl/glitch_filt_sync.sv
module glitch_filt_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);

  logic [STAGES-1:0] stage_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= d_i;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q <= '0;
        else         stage_q <= {stage_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/glitch_filt_decode.sv
module glitch_filt_decode
  import glitch_filt_pkg::*;
#(
  parameter int unsigned CODE_W = 4,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              bypass_o,
  output logic [CNT_W-1:0]  limit_o,
  output logic              restart_o
);

  logic [CODE_W-1:0] code_q;
  logic [CNT_W-1:0]  lim_bit [CODE_W];
  logic [$clog2(CODE_W+1)-1:0] ones;

  genvar gi;
  generate
    for (gi = 0; gi < CODE_W; gi++) begin : g_lim
      // terminal count is periods-1
      assign lim_bit[gi] = CNT_W'(periods_for_bit(gi) - 1);
    end
  endgenerate

  always_comb begin
    ones    = '0;
    limit_o = '0;
    for (int i = 0; i < CODE_W; i++) begin
      ones = ones + code_i[i];
      if (code_i[i]) limit_o = lim_bit[i];
    end
    bypass_o = (ones != 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) code_q <= '0;
    else         code_q <= code_i;
  end

  assign restart_o = (code_q != code_i);

endmodule

// File: rtl/glitch_filt_core.sv
module glitch_filt_core #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic             bypass_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             restart_i,
  input  logic             tick_i,
  output logic             filt_o
);

  logic             out_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      cnt_q <= '0;
    end else if (bypass_i) begin
      out_q <= sync_i;
      cnt_q <= '0;
    end else if (restart_i || (sync_i == out_q)) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == limit_i) begin
        out_q <= sync_i;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign filt_o = out_q;

  a_r2_bypass_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bypass_i |=> (out_q == $past(sync_i)));

  a_r4_count_bounded: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && !restart_i) |-> (cnt_q <= limit_i));

  a_r6_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bypass_i && !tick_i) |=> $stable(out_q));

  a_r7_equal_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_i == out_q) |=> $stable(out_q));

  a_r8_restart_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (restart_i && !bypass_i) |=> $stable(out_q));

endmodule

// File: rtl/glitch_filt.sv
module glitch_filt
  import glitch_filt_pkg::*;
#(
  parameter int unsigned CODE_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              raw_i,
  input  logic [CODE_W-1:0] width_code_i,
  input  logic              fclk_sel_i,
  input  logic              tick_i,
  output logic              filt_o
);

  localparam int unsigned MAX_PERIODS = 2 << (CODE_W - 1);
  localparam int unsigned CNT_W       = $clog2(MAX_PERIODS);

  logic             sync_lvl;
  logic             bypass;
  logic             restart;
  logic [CNT_W-1:0] limit;
  logic             tick_eff;

  glitch_filt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_i),
    .q_o    (sync_lvl)
  );

  glitch_filt_decode #(.CODE_W(CODE_W), .CNT_W(CNT_W)) u_dec (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .code_i    (width_code_i),
    .bypass_o  (bypass),
    .limit_o   (limit),
    .restart_o (restart)
  );

  assign tick_eff = (fclk_sel_e'(fclk_sel_i) == FCLK_MAIN) ? 1'b1 : tick_i;

  glitch_filt_core #(.CNT_W(CNT_W)) u_core (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_lvl),
    .bypass_i  (bypass),
    .limit_i   (limit),
    .restart_i (restart),
    .tick_i    (tick_eff),
    .filt_o    (filt_o)
  );

  a_r9_main_clock_ticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fclk_sel_i |-> tick_eff);

endmodule

// File: tb/tb_glitch_filt.sv
`timescale 1ns/1ps
module tb_glitch_filt;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       raw_i = 1'b0;
  logic [3:0] width_code_i = 4'b0000;
  logic       fclk_sel_i = 1'b1;
  logic       tick_i = 1'b0;
  logic       filt_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk_i = ~clk_i;

  glitch_filt dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .raw_i        (raw_i),
    .width_code_i (width_code_i),
    .fclk_sel_i   (fclk_sel_i),
    .tick_i       (tick_i),
    .filt_o       (filt_o)
  );

  typedef struct packed {
    logic [3:0] code;
    logic [7:0] len;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 8'd1},  '{4'b0000, 8'd4},
    '{4'b0001, 8'd1},  '{4'b0001, 8'd2},
    '{4'b0010, 8'd3},  '{4'b0010, 8'd4},
    '{4'b0100, 8'd7},  '{4'b0100, 8'd8},
    '{4'b1000, 8'd15}, '{4'b1000, 8'd16},
    '{4'b0011, 8'd1},  '{4'b0110, 8'd1},
    '{4'b1111, 8'd1}
  };

  function automatic int width_of(input logic [3:0] c);
    case (c)
      4'b0001: return 2;
      4'b0010: return 4;
      4'b0100: return 8;
      4'b1000: return 16;
      default: return 0;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic edge_wait(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic settle();
    fclk_sel_i = 1'b1;
    tick_i     = 1'b0;
    raw_i      = 1'b0;
    edge_wait(40);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset holds output low even with raw high
    raw_i = 1'b1;
    edge_wait(5);
    check(filt_o == 1'b0, "R1 in reset", filt_o, 0);
    rst_ni = 1'b1;
    raw_i  = 1'b0;
    edge_wait(1);
    check(filt_o == 1'b0, "R1 after release", filt_o, 0);
    settle();

    // table: bypass, reserved and one-hot widths with main clock
    for (int v = 0; v < NV; v++) begin
      int n;
      int len;
      int first;
      bit bypass;
      bit exp_pass;
      int exp_edge;
      string tag;
      width_code_i = VECS[v].code;
      len   = int'(VECS[v].len);
      n     = width_of(VECS[v].code);
      bypass = (n == 0);
      exp_pass = bypass || (len >= n);
      exp_edge = bypass ? 3 : n + 2;
      if (bypass) tag = (VECS[v].code == 4'b0000) ? "R2" : "R3";
      else        tag = exp_pass ? "R4" : "R5";
      if (bypass && VECS[v].code != 4'b0000)
        $display("note: reserved width code %b used as bypass", VECS[v].code);
      settle();
      raw_i = 1'b1;
      first = 0;
      for (int k = 1; k <= 60; k++) begin
        edge_wait(1);
        if (k == len) raw_i = 1'b0;
        if (filt_o && first == 0) first = k;
      end
      check((first != 0) == exp_pass, tag, int'(first != 0), int'(exp_pass));
      if (exp_pass) check(first == exp_edge, {tag, " edge"}, first, exp_edge);
      check(filt_o == 1'b0, {tag, " return low"}, filt_o, 0);
    end

    // R7: two 3-cycle pulses with a 1-cycle gap under N=4
    begin
      bit seen;
      width_code_i = 4'b0010;
      settle();
      seen = 1'b0;
      raw_i = 1'b1;
      for (int k = 1; k <= 30; k++) begin
        edge_wait(1);
        if (k == 3) raw_i = 1'b0;
        if (k == 4) raw_i = 1'b1;
        if (k == 7) raw_i = 1'b0;
        if (filt_o) seen = 1'b1;
      end
      check(!seen, "R7 no accumulation", seen, 0);
    end

    // R8: switch 16 -> 4 after three counted periods
    begin
      width_code_i = 4'b1000;
      settle();
      raw_i = 1'b1;
      for (int k = 1; k <= 12; k++) begin
        edge_wait(1);
        if (k == 5) width_code_i = 4'b0010;
        if (k == 9)  check(filt_o == 1'b0, "R8 before restart done", filt_o, 0);
        if (k == 10) check(filt_o == 1'b1, "R8 after restart", filt_o, 1);
      end
      raw_i = 1'b0;
    end

    // R9: main clock ignores idle tick
    begin
      int first;
      width_code_i = 4'b0010;
      settle();
      tick_i = 1'b0;
      raw_i  = 1'b1;
      first  = 0;
      for (int k = 1; k <= 20; k++) begin
        edge_wait(1);
        if (k == 4) raw_i = 1'b0;
        if (filt_o && first == 0) first = k;
      end
      check(first == 6, "R9 tick ignored", first, 6);
    end

    // R6: prescaled time base, N=2
    begin
      width_code_i = 4'b0001;
      settle();
      fclk_sel_i = 1'b0;
      tick_i = 1'b0;
      raw_i  = 1'b1;
      edge_wait(20);
      check(filt_o == 1'b0, "R6 no ticks", filt_o, 0);
      tick_i = 1'b1;
      edge_wait(1);
      tick_i = 1'b0;
      check(filt_o == 1'b0, "R6 first tick", filt_o, 0);
      edge_wait(2);
      check(filt_o == 1'b0, "R6 between ticks", filt_o, 0);
      tick_i = 1'b1;
      edge_wait(1);
      tick_i = 1'b0;
      check(filt_o == 1'b1, "R6 second tick", filt_o, 1);
      settle();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule